// File: doc/BRIEF.md
# Sound-Coprocessor Bus Decoder

This block sits on the 16-bit address bus of an 8-bit sound coprocessor, between the processor and its 64 KiB local RAM. It steers each access to the RAM, to a small boot ROM mapped over the top of the address space, to a page of sixteen registers at 0x00F0–0x00FF, or to an indirect port into the DSP register file. The register page holds a test register, a control register, the DSP address and data pair, four host-communication ports, two scratch bytes, and the strobes that load and read the timers.

Reads are combinational from the address: `cpu_rdata` is valid in the cycle that the address is presented. Writes take effect at the rising clock edge while `cpu_wr` is high. Every write is also sent to the RAM write path, including writes to the register page and to the ROM window. The ROM overlay only changes what reads return. A RAM-disable bit replaces all reads that fall through to RAM with a fixed byte. Host ports are split: the coprocessor reads bytes that the host wrote, and its own writes go to separate latches that the host reads. The timer counters and the DSP internals are outside this block.

Top module: `snd_bus_decoder`

## Requirements
- R1: While control bit 7 (ROM enable) is 1, a read in 0xFFC0–0xFFFF returns the ROM byte at offset addr[5:0]. While it is 0, the read returns RAM.
- R2: Every CPU write asserts the RAM write path with the same address and data, when R3 allows it. This covers writes to register addresses and to the ROM window.
- R3: The RAM write strobe is high only while test bit 1 (RAM writable) is 1 and test bit 2 (RAM disable) is 0.
- R4: While test bit 2 is 1, reads that fall through to RAM return 0x5A. ROM and register reads are not affected.
- R5: The test register at 0xF0 drives clk_speed from bits 7:6, tmr_speed from bits 5:4, tmr_run from bit 3, RAM disable from bit 2, RAM writable from bit 1 and tmr_halt from bit 0. A write to it is ignored while cpu_pflag is 1.
- R6: The control register at 0xF1 sets the ROM enable from bit 7 and tmr_en[2:0] from bits 2:0. For one cycle after the write, tmr_start[i] is 1 for each timer whose enable went from 0 to 1.
- R7: A write to 0xF1 with bit 4 set clears host input ports 0 and 1. With bit 5 set, it clears ports 2 and 3. The clear wins over a host write to the same port in the same cycle.
- R8: 0xF2 is the DSP address and can be read and written. Accesses at 0xF3 reach DSP register (dsp address & 0x7F). A write at 0xF3 is dropped while dsp address bit 7 is 1, so that half reads as a mirror.
- R9: 0xF0, 0xF1 and 0xFA–0xFC read as 0x00. A write to 0xFA+i pulses tmr_tgt_we[i] and presents the write data on tmr_tgt_data.
- R10: 0xF8 and 0xF9 are scratch bytes that can be read and written.
- R11: A read at 0xF4+i returns the byte the host last wrote to port i. A write at 0xF4+i sets host_out byte i (bits 8i+7:8i).
- R12: A read at 0xFD+i returns {4'b0, tmr_cnt[4i+3:4i]} and pulses tmr_rd[i] while cpu_rd is 1.
- R13: After reset, the ROM overlay is on, RAM is writable and enabled, the test fields are 0, all timer enables and start pulses are 0, and all ports and scratch bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_pflag | input | 1 | Processor P flag; blocks test-register writes |
| cpu_rdata | output | 8 | CPU read data |
| ram_addr | output | 16 | RAM address |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| rom_addr | output | ROM_AW | Boot ROM offset |
| rom_rdata | input | 8 | Boot ROM data |
| dsp_addr | output | 7 | DSP register index |
| dsp_we | output | 1 | DSP register write strobe |
| dsp_wdata | output | 8 | DSP write data |
| dsp_rdata | input | 8 | DSP register data |
| host_we | input | 1 | Host write strobe for an input port |
| host_sel | input | 2 | Host port select |
| host_wdata | input | 8 | Host write data |
| host_out | output | 32 | Output port latches, byte i = port i |
| clk_speed | output | 2 | Test register clock-speed field |
| tmr_speed | output | 2 | Test register timer-speed field |
| tmr_run | output | 1 | Timers-enable field |
| tmr_halt | output | 1 | Timers-disable field |
| tmr_en | output | 3 | Per-timer enables |
| tmr_start | output | 3 | One-cycle restart pulse on a 0-to-1 enable |
| tmr_tgt_we | output | 3 | Timer target load strobes |
| tmr_tgt_data | output | 8 | Timer target value |
| tmr_rd | output | 3 | Timer counter read strobes |
| tmr_cnt | input | 12 | Three 4-bit timer counter values |

## Verification
The bench reads back a byte written at 0xFFC5 with the overlay on and then off. A decoder that let ROM catch writes, or that ignored the enable bit, returns the wrong byte. It writes the DSP port through an address with bit 7 set and expects the older value back. A design that wrote through the mirror would overwrite it. It also tries test-register writes with the P flag high, RAM writes while protected or disabled, and a host write that lands in the same cycle as a port clear. Each of these would leave a changed byte or a missing 0x5A at the RAM or port read. Finally, it enables a timer twice and expects exactly one start pulse.

// File: rtl/snd_bus_decoder.sv
module snd_bus_decoder #(
  parameter logic [7:0] RAM_OFF_BYTE = 8'h5A,
  parameter logic [7:0] TEST_RST     = 8'h02,
  parameter int         ROM_AW       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              cpu_pflag,
  output logic [7:0]        cpu_rdata,
  output logic [15:0]       ram_addr,
  output logic              ram_we,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [7:0]        rom_rdata,
  output logic [6:0]        dsp_addr,
  output logic              dsp_we,
  output logic [7:0]        dsp_wdata,
  input  logic [7:0]        dsp_rdata,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [7:0]        host_wdata,
  output logic [31:0]       host_out,
  output logic [1:0]        clk_speed,
  output logic [1:0]        tmr_speed,
  output logic              tmr_run,
  output logic              tmr_halt,
  output logic [2:0]        tmr_en,
  output logic [2:0]        tmr_start,
  output logic [2:0]        tmr_tgt_we,
  output logic [7:0]        tmr_tgt_data,
  output logic [2:0]        tmr_rd,
  input  logic [11:0]       tmr_cnt
);

  localparam logic [15:0] ROM_MASK = ~((16'd1 << ROM_AW) - 16'd1);

  logic [7:0] test_q, dsp_a_q, scr0_q, scr1_q;
  logic       rom_en_q;
  logic [2:0] ten_q, tstart_q;
  logic [7:0] hin_q [4];
  logic [7:0] hout_q [4];

  logic       reg_hit, wr_reg, in_rom;
  logic [3:0] ra;

  assign reg_hit = (cpu_addr[15:4] == 12'h00F);
  assign ra      = cpu_addr[3:0];
  assign wr_reg  = cpu_wr & reg_hit;
  assign in_rom  = (cpu_addr & ROM_MASK) == ROM_MASK;

  assign ram_addr  = cpu_addr;
  assign ram_wdata = cpu_wdata;
  assign ram_we    = cpu_wr & test_q[1] & ~test_q[2];
  assign rom_addr  = cpu_addr[ROM_AW-1:0];
  assign dsp_addr  = dsp_a_q[6:0];
  assign dsp_wdata = cpu_wdata;
  assign dsp_we    = wr_reg & (ra == 4'h3) & ~dsp_a_q[7];

  assign clk_speed    = test_q[7:6];
  assign tmr_speed    = test_q[5:4];
  assign tmr_run      = test_q[3];
  assign tmr_halt     = test_q[0];
  assign tmr_en       = ten_q;
  assign tmr_start    = tstart_q;
  assign tmr_tgt_data = cpu_wdata;
  assign host_out     = {hout_q[3], hout_q[2], hout_q[1], hout_q[0]};

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      tmr_tgt_we[i] = wr_reg & (ra == 4'(10 + i));
      tmr_rd[i]     = cpu_rd & reg_hit & (ra == 4'(13 + i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_q   <= TEST_RST;
      rom_en_q <= 1'b1;
      ten_q    <= 3'b0;
      tstart_q <= 3'b0;
      dsp_a_q  <= 8'h00;
      scr0_q   <= 8'h00;
      scr1_q   <= 8'h00;
      for (int i = 0; i < 4; i++) begin
        hin_q[i]  <= 8'h00;
        hout_q[i] <= 8'h00;
      end
    end else begin
      tstart_q <= (wr_reg && ra == 4'h1) ? (cpu_wdata[2:0] & ~ten_q) : 3'b0;
      if (wr_reg) begin
        case (ra)
          4'h0: if (!cpu_pflag) test_q <= cpu_wdata;
          4'h1: begin
            rom_en_q <= cpu_wdata[7];
            ten_q    <= cpu_wdata[2:0];
          end
          4'h2: dsp_a_q <= cpu_wdata;
          4'h4, 4'h5, 4'h6, 4'h7: hout_q[ra[1:0]] <= cpu_wdata;
          4'h8: scr0_q <= cpu_wdata;
          4'h9: scr1_q <= cpu_wdata;
          default: ;
        endcase
      end
      for (int i = 0; i < 4; i++) begin
        if (wr_reg && ra == 4'h1 && cpu_wdata[4 + i / 2])
          hin_q[i] <= 8'h00;
        else if (host_we && host_sel == 2'(i))
          hin_q[i] <= host_wdata;
      end
    end
  end

  always_comb begin
    cpu_rdata = 8'h00;
    if (reg_hit) begin
      case (ra)
        4'h2: cpu_rdata = dsp_a_q;
        4'h3: cpu_rdata = dsp_rdata;
        4'h4, 4'h5, 4'h6, 4'h7: cpu_rdata = hin_q[ra[1:0]];
        4'h8: cpu_rdata = scr0_q;
        4'h9: cpu_rdata = scr1_q;
        4'hD: cpu_rdata = {4'h0, tmr_cnt[3:0]};
        4'hE: cpu_rdata = {4'h0, tmr_cnt[7:4]};
        4'hF: cpu_rdata = {4'h0, tmr_cnt[11:8]};
        default: cpu_rdata = 8'h00;
      endcase
    end else if (rom_en_q && in_rom) begin
      cpu_rdata = rom_rdata;
    end else if (test_q[2]) begin
      cpu_rdata = RAM_OFF_BYTE;
    end else begin
      cpu_rdata = ram_rdata;
    end
  end

  // R1
  rom_overlay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_en_q && in_rom) |-> cpu_rdata == rom_rdata);

  // R4
  ram_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_hit && !(rom_en_q && in_rom) && test_q[2]) |-> cpu_rdata == RAM_OFF_BYTE);

  // R5
  test_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reg && ra == 4'h0 && cpu_pflag) |=> $stable({clk_speed, tmr_speed, tmr_run, tmr_halt}));

  // R6
  start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_start != 3'b0) |-> ((tmr_start & ~tmr_en) == 3'b0 && (tmr_start & $past(tmr_en)) == 3'b0));

  // R7
  port_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reg && ra == 4'h1 && cpu_wdata[4]) |=> (hin_q[0] == 8'h00 && hin_q[1] == 8'h00));

  // R8
  dsp_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reg && ra == 4'h2) |=> dsp_addr == $past(cpu_wdata[6:0]));

endmodule

// File: tb/snd_bus_decoder_bench.sv
module snd_bus_decoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_pflag = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [15:0] ram_addr;
  logic        ram_we;
  logic [7:0]  ram_wdata, ram_rdata;
  logic [5:0]  rom_addr;
  logic [7:0]  rom_rdata;
  logic [6:0]  dsp_addr;
  logic        dsp_we;
  logic [7:0]  dsp_wdata, dsp_rdata;
  logic        host_we = 1'b0;
  logic [1:0]  host_sel = '0;
  logic [7:0]  host_wdata = '0;
  logic [31:0] host_out;
  logic [1:0]  clk_speed, tmr_speed;
  logic        tmr_run, tmr_halt;
  logic [2:0]  tmr_en, tmr_start, tmr_tgt_we, tmr_rd;
  logic [7:0]  tmr_tgt_data;
  logic [11:0] tmr_cnt = 12'hA53;

  logic [7:0] ram_m [1024];
  logic [7:0] dsp_m [128];
  assign ram_rdata = ram_m[{ram_addr[15], ram_addr[8:0]}];
  assign rom_rdata = {2'b10, rom_addr} ^ 8'h33;
  assign dsp_rdata = dsp_m[dsp_addr];
  always @(posedge clk) begin
    if (ram_we) ram_m[{ram_addr[15], ram_addr[8:0]}] <= ram_wdata;
    if (dsp_we) dsp_m[dsp_addr] <= dsp_wdata;
  end

  snd_bus_decoder u_snd_bus_decoder (
    .clk, .rst_n, .cpu_addr, .cpu_wdata, .cpu_rd, .cpu_wr, .cpu_pflag, .cpu_rdata,
    .ram_addr, .ram_we, .ram_wdata, .ram_rdata, .rom_addr, .rom_rdata,
    .dsp_addr, .dsp_we, .dsp_wdata, .dsp_rdata, .host_we, .host_sel, .host_wdata,
    .host_out, .clk_speed, .tmr_speed, .tmr_run, .tmr_halt, .tmr_en, .tmr_start,
    .tmr_tgt_we, .tmr_tgt_data, .tmr_rd, .tmr_cnt);

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h, expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic hwr(input logic [1:0] p, input logic [7:0] d);
    @(negedge clk);
    host_sel = p; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1 chk(req, cpu_rdata, exp);
    cpu_rd = 1'b0;
  endtask

  // {op[1:0], addr[15:0], data[7:0], exp[7:0], req[3:0]}; op 0 read, 1 cpu write, 2 host write
  localparam int NV = 28;
  localparam logic [37:0] VEC [NV] = '{
    {2'd1, 16'h0010, 8'hAB, 8'h00, 4'd2},   // R2
    {2'd0, 16'h0010, 8'h00, 8'hAB, 4'd2},   // R2
    {2'd1, 16'hFFC5, 8'h77, 8'h00, 4'd1},   // R1
    {2'd0, 16'hFFC5, 8'h00, 8'hB6, 4'd1},   // R1
    {2'd1, 16'h00F8, 8'h3C, 8'h00, 4'd10},  // R10
    {2'd1, 16'h00F9, 8'hC3, 8'h00, 4'd10},
    {2'd0, 16'h00F8, 8'h00, 8'h3C, 4'd10},
    {2'd0, 16'h00F9, 8'h00, 8'hC3, 4'd10},
    {2'd1, 16'h00F2, 8'h05, 8'h00, 4'd8},   // R8
    {2'd1, 16'h00F3, 8'h99, 8'h00, 4'd8},
    {2'd0, 16'h00F3, 8'h00, 8'h99, 4'd8},
    {2'd1, 16'h00F2, 8'h85, 8'h00, 4'd8},
    {2'd1, 16'h00F3, 8'h11, 8'h00, 4'd8},
    {2'd0, 16'h00F3, 8'h00, 8'h99, 4'd8},
    {2'd0, 16'h00F2, 8'h00, 8'h85, 4'd8},
    {2'd0, 16'h00F0, 8'h00, 8'h00, 4'd9},   // R9
    {2'd1, 16'h00FA, 8'h12, 8'h00, 4'd9},
    {2'd0, 16'h00FA, 8'h00, 8'h00, 4'd9},
    {2'd0, 16'h00F1, 8'h00, 8'h00, 4'd9},
    {2'd0, 16'h00FD, 8'h00, 8'h03, 4'd12},  // R12
    {2'd0, 16'h00FE, 8'h00, 8'h05, 4'd12},
    {2'd0, 16'h00FF, 8'h00, 8'h0A, 4'd12},
    {2'd2, 16'h0001, 8'h42, 8'h00, 4'd11},  // R11
    {2'd0, 16'h00F5, 8'h00, 8'h42, 4'd11},
    {2'd1, 16'h00F1, 8'h00, 8'h00, 4'd1},   // R1 overlay off
    {2'd0, 16'hFFC5, 8'h00, 8'h77, 4'd1},
    {2'd1, 16'h00F1, 8'h80, 8'h00, 4'd1},
    {2'd0, 16'hFFC5, 8'h00, 8'hB6, 4'd1}
  };

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) ram_m[i] = 8'h00;
    for (int i = 0; i < 128; i++) dsp_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R13 reset state
    #1;
    chk("R13 tmr_en", tmr_en, 3'b0);
    chk("R13 tmr_start", tmr_start, 3'b0);
    chk("R13 test fields", {clk_speed, tmr_speed, tmr_run, tmr_halt}, 6'b0);
    chk("R13 host_out", host_out, 32'h0);
    rd("R13 overlay on", 16'hFFC0, 8'h80 ^ 8'h33);

    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      v = VEC[i];
      case (v[37:36])
        2'd0: rd($sformatf("R%0d vec %0d", v[3:0], i), v[35:20], v[11:4]);
        2'd1: wr(v[35:20], v[19:12]);
        default: hwr(v[21:20], v[19:12]);
      endcase
    end

    // R5 field decode and P-flag block
    wr(16'h00F0, 8'hDB);
    chk("R5 fields", {clk_speed, tmr_speed, tmr_run, tmr_halt}, {2'd3, 2'd1, 1'b1, 1'b1});
    cpu_pflag = 1'b1;
    wr(16'h00F0, 8'h02);
    chk("R5 pflag ignore", {clk_speed, tmr_speed, tmr_run, tmr_halt}, {2'd3, 2'd1, 1'b1, 1'b1});
    cpu_pflag = 1'b0;
    wr(16'h00F0, 8'h02);
    chk("R5 cleared", {clk_speed, tmr_speed, tmr_run, tmr_halt}, 6'b0);
    cpu_pflag = 1'b1;
    wr(16'h00F0, 8'h06);
    cpu_pflag = 1'b0;
    rd("R5 pflag no disable", 16'h0010, 8'hAB);

    // R4 / R3 RAM disable and write protect
    wr(16'h00F0, 8'h06);
    rd("R4 fixed byte", 16'h0010, 8'h5A);
    rd("R4 rom unaffected", 16'hFFC5, 8'hB6);
    rd("R4 reg unaffected", 16'h00F8, 8'h3C);
    wr(16'h0010, 8'h00);
    wr(16'h00F0, 8'h02);
    rd("R3 disabled blocks write", 16'h0010, 8'hAB);
    wr(16'h00F0, 8'h00);
    wr(16'h0010, 8'h55);
    wr(16'h00F0, 8'h02);
    rd("R3 unwritable blocks write", 16'h0010, 8'hAB);

    // R2 register write also reaches RAM path
    @(negedge clk);
    cpu_addr = 16'h00F9; cpu_wdata = 8'h5E; cpu_wr = 1'b1;
    #1 chk("R2 write-through", {ram_we, ram_addr, ram_wdata}, {1'b1, 16'h00F9, 8'h5E});
    @(negedge clk); cpu_wr = 1'b0;

    // R9 target strobe
    @(negedge clk);
    cpu_addr = 16'h00FB; cpu_wdata = 8'h44; cpu_wr = 1'b1;
    #1 chk("R9 target strobe", {tmr_tgt_we, tmr_tgt_data}, {3'b010, 8'h44});
    @(negedge clk); cpu_wr = 1'b0;

    // R12 read strobe
    @(negedge clk);
    cpu_addr = 16'h00FE; cpu_rd = 1'b1;
    #1 chk("R12 read strobe", tmr_rd, 3'b010);
    cpu_rd = 1'b0;

    // R11 output latch
    wr(16'h00F6, 8'hEE);
    chk("R11 host_out", host_out[23:16], 8'hEE);

    // R7 port clears
    hwr(2'd0, 8'h11); hwr(2'd1, 8'h22); hwr(2'd2, 8'h33); hwr(2'd3, 8'h44);
    wr(16'h00F1, 8'h90);
    rd("R7 port0 cleared", 16'h00F4, 8'h00);
    rd("R7 port1 cleared", 16'h00F5, 8'h00);
    rd("R7 port2 kept", 16'h00F6, 8'h33);
    @(negedge clk);
    cpu_addr = 16'h00F1; cpu_wdata = 8'hA0; cpu_wr = 1'b1;
    host_sel = 2'd3; host_wdata = 8'h55; host_we = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0; host_we = 1'b0;
    rd("R7 port2 cleared", 16'h00F6, 8'h00);
    rd("R7 clear beats host", 16'h00F7, 8'h00);

    // R6 timer enable edge
    wr(16'h00F1, 8'h81);
    chk("R6 enable", tmr_en, 3'b001);
    chk("R6 start pulse", tmr_start, 3'b001);
    @(negedge clk);
    chk("R6 pulse one cycle", tmr_start, 3'b000);
    wr(16'h00F1, 8'h83);
    chk("R6 only new edge", tmr_start, 3'b010);
    rd("R6 rom still on", 16'hFFC5, 8'hB6);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule